// File: doc/BRIEF.md
# Memory Fault Exception Classifier

This block sits beside the load/store and fetch paths of a CPU core and turns raw memory-fault indications into an exception request. Each cycle it looks at the kind of access in flight (instruction fetch, data load or data store), the virtual address involved, and two fault strobes: one for a misaligned address, one for a bus error returned by the memory system. From these it produces a one-cycle exception strobe with an exception code, plus a flag that marks fetch-side address faults as "instruction not available".

On an address fault the offending virtual address is latched into a bad-address register, with a write-enable pulse, unless the core is in debug mode. Data-side bus errors can be switched off by a configuration input. Fetch-side bus errors always raise. When both strobes arrive together, the address fault wins.

Top module: `mfc_fault_classifier`

## Requirements
- R1: While reset is asserted and after it is released, with no fault strobe yet seen, exc_valid, exc_code, exc_fetch_na, badaddr_we and badaddr are all zero. Asserting reset in the middle of operation clears them at once.
- R2: A misaligned access with acc_type = 2 (store) produces exc_code 5 on the cycle after the strobe is sampled.
- R3: A misaligned access with acc_type = 0 (fetch), 1 (load) or 3 (reserved, treated as load) produces exc_code 4.
- R4: exc_fetch_na is 1 only together with a misalignment exception on a fetch (acc_type = 0). It is 0 for every other exception and while exc_valid is low.
- R5: On a misaligned access with debug_mode low, badaddr takes fault_addr and badaddr_we pulses for one cycle. With debug_mode high, badaddr keeps its value and badaddr_we stays low.
- R6: A bus error on a fetch produces exc_code 6, whatever the value of suppress_dbe.
- R7: A bus error on a data access (acc_type 1, 2 or 3) produces exc_code 7 when suppress_dbe is 0. When suppress_dbe is 1, no exception is raised: exc_valid and exc_code stay 0.
- R8: When misalign and bus_err are both high in one cycle, the address-error code, flag and bad-address capture apply and the bus error is dropped, even if it would have been suppressed.
- R9: exc_valid is high in the cycle after each cycle in which a raising fault is sampled, and low otherwise. A strobe held for N cycles gives N consecutive pulses. With no exception, exc_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved (load) |
| fault_addr | input | ADDR_W | Virtual address of the access |
| misalign | input | 1 | Address misalignment strobe |
| bus_err | input | 1 | Bus error strobe |
| debug_mode | input | 1 | Core in debug mode; blocks bad-address capture |
| suppress_dbe | input | 1 | Masks data-side bus-error exceptions |
| exc_valid | output | 1 | Registered exception strobe |
| exc_code | output | CODE_W | Registered exception code, 0 when idle |
| exc_fetch_na | output | 1 | Instruction-not-available error-code flag |
| badaddr | output | ADDR_W | Bad virtual address register |
| badaddr_we | output | 1 | One-cycle pulse when badaddr is written |

## Verification
A vector table drives misalignment alone on each access type: fetch, load and store tell the store code apart from the load code and isolate the fetch flag. The reserved type shows that it falls on the load side. Each of these runs with debug mode low and high, which separates capture from hold of the bad address. Bus errors alone go through each access type with the mask off and on, which shows that only data-side errors can be masked. Simultaneous strobes, including a masked bus error, prove the priority. Directed sequences then hold a strobe for several cycles, go idle, and assert reset in the middle of a run, which shows one pulse per faulting cycle and the asynchronous clear.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_NONE     = 5'd0;
  localparam logic [CODE_W-1:0] CODE_ADDR_LD  = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADDR_ST  = 5'd5;
  localparam logic [CODE_W-1:0] CODE_BUS_INST = 5'd6;
  localparam logic [CODE_W-1:0] CODE_BUS_DATA = 5'd7;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
    logic              fetch_na;
    logic              capture;
  } fault_t;

endpackage

// File: rtl/mfc_rst_sync.sv
module mfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mfc_decode.sv
module mfc_decode
  import mfc_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic       misalign,
  input  logic       bus_err,
  input  logic       debug_mode,
  input  logic       suppress_dbe,
  output fault_t     fault
);
  acc_e acc;
  logic is_fetch;
  logic is_store;
  logic addr_fault;
  logic bus_fault;

  always_comb begin
    acc        = acc_e'(acc_type);
    is_fetch   = (acc == ACC_FETCH);
    is_store   = (acc == ACC_STORE);
    addr_fault = misalign;
    bus_fault  = bus_err && (is_fetch || !suppress_dbe);
  end

  always_comb begin
    fault = '0;
    if (addr_fault) begin
      fault.valid    = 1'b1;
      fault.code     = is_store ? CODE_ADDR_ST : CODE_ADDR_LD;
      fault.fetch_na = is_fetch;
      fault.capture  = !debug_mode;
    end else if (bus_fault) begin
      fault.valid = 1'b1;
      fault.code  = is_fetch ? CODE_BUS_INST : CODE_BUS_DATA;
    end
  end

  always_comb begin
    if (fault.fetch_na) assert (fault.valid && fault.code == CODE_ADDR_LD)
      else $error("a_r4_flag_with_addr_code");
  end
endmodule

// File: rtl/mfc_exc_reg.sv
module mfc_exc_reg
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fault_t            fault,
  output logic              exc_valid,
  output logic [CODE_W-1:0] exc_code,
  output logic              exc_fetch_na
);
  logic              valid_d, valid_q;
  logic [CODE_W-1:0] code_d,  code_q;
  logic              na_d,    na_q;

  always_comb begin
    valid_d = fault.valid;
    code_d  = fault.valid ? fault.code : CODE_NONE;
    na_d    = fault.valid && fault.fetch_na;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= CODE_NONE;
      na_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      code_q  <= code_d;
      na_q    <= na_d;
    end
  end

  assign exc_valid    = valid_q;
  assign exc_code     = code_q;
  assign exc_fetch_na = na_q;

  a_r9_code_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> exc_code == CODE_NONE && !exc_fetch_na);
endmodule

// File: rtl/mfc_badaddr.sv
module mfc_badaddr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] badaddr,
  output logic              badaddr_we
);
  logic              en;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              we_d,   we_q;

  always_comb begin
    en     = capture;
    addr_d = addr;
    we_d   = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  assign badaddr    = addr_q;
  assign badaddr_we = we_q;

  a_r5_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> badaddr == $past(addr) && badaddr_we);
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(badaddr) && !badaddr_we);
endmodule

// File: rtl/mfc_fault_classifier.sv
module mfc_fault_classifier
  import mfc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_type,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              misalign,
  input  logic              bus_err,
  input  logic              debug_mode,
  input  logic              suppress_dbe,
  output logic              exc_valid,
  output logic [CODE_W-1:0] exc_code,
  output logic              exc_fetch_na,
  output logic [ADDR_W-1:0] badaddr,
  output logic              badaddr_we
);
  logic   rst_i_n;
  fault_t fault;

  mfc_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mfc_decode u_dec (
    .acc_type     (acc_type),
    .misalign     (misalign),
    .bus_err      (bus_err),
    .debug_mode   (debug_mode),
    .suppress_dbe (suppress_dbe),
    .fault        (fault)
  );

  mfc_exc_reg u_exc (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .fault        (fault),
    .exc_valid    (exc_valid),
    .exc_code     (exc_code),
    .exc_fetch_na (exc_fetch_na)
  );

  mfc_badaddr #(.ADDR_W(ADDR_W)) u_bad (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .capture    (fault.capture),
    .addr       (fault_addr),
    .badaddr    (badaddr),
    .badaddr_we (badaddr_we)
  );

  a_r2_store_addr_code: assert property (@(posedge clk) disable iff (!rst_i_n)
    (misalign && acc_type == 2'd2) |=> exc_valid && exc_code == CODE_ADDR_ST);
  a_r3_load_addr_code: assert property (@(posedge clk) disable iff (!rst_i_n)
    (misalign && acc_type != 2'd2) |=> exc_valid && exc_code == CODE_ADDR_LD);
  a_r4_fetch_flag: assert property (@(posedge clk) disable iff (!rst_i_n)
    misalign |=> exc_fetch_na == ($past(acc_type) == 2'd0));
  a_r6_fetch_bus_code: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_err && !misalign && acc_type == 2'd0) |=> exc_valid && exc_code == CODE_BUS_INST);
  a_r7_data_bus_masked: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_err && !misalign && acc_type != 2'd0 && suppress_dbe) |=> !exc_valid);
  a_r8_debug_blocks_capture: assert property (@(posedge clk) disable iff (!rst_i_n)
    debug_mode |=> !badaddr_we);
  a_r9_no_fault_no_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!misalign && !bus_err) |=> !exc_valid);
endmodule

// File: tb/test_mfc_fault_classifier.sv
`timescale 1ns/1ps
module test_mfc_fault_classifier;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  acc_type;
  logic [31:0] fault_addr;
  logic        misalign, bus_err, debug_mode, suppress_dbe;
  logic        exc_valid, exc_fetch_na, badaddr_we;
  logic [4:0]  exc_code;
  logic [31:0] badaddr;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_bad;

  always #4 clk = ~clk;

  mfc_fault_classifier i_mfc_fault_classifier (
    .clk(clk), .rst_n(rst_n), .acc_type(acc_type), .fault_addr(fault_addr),
    .misalign(misalign), .bus_err(bus_err), .debug_mode(debug_mode),
    .suppress_dbe(suppress_dbe), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_fetch_na(exc_fetch_na), .badaddr(badaddr), .badaddr_we(badaddr_we)
  );

  // {type, mis, bus, dbg, sup, addr, exp_valid, exp_code, exp_flag, exp_we}
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1001_0002, 1'b1, 5'd4, 1'b1, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2000_0003, 1'b1, 5'd4, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h3000_0001, 1'b1, 5'd5, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h4000_0005, 1'b1, 5'd5, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h5000_0006, 1'b1, 5'd4, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h6000_0000, 1'b1, 5'd6, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h6000_0010, 1'b1, 5'd6, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h6000_0020, 1'b1, 5'd7, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h6000_0030, 1'b1, 5'd7, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h6000_0040, 1'b0, 5'd0, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 32'h6000_0050, 1'b0, 5'd0, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h7000_0007, 1'b1, 5'd5, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8000_0001, 1'b1, 5'd4, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 32'h9000_0002, 1'b1, 5'd4, 1'b0, 1'b1},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h9000_0100, 1'b1, 5'd7, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h9000_0200, 1'b0, 5'd0, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 32'hA000_0003, 1'b1, 5'd4, 1'b0, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 4:            return "R3/R4 fetch misalign";
      1, 14:           return "R3 load misalign";
      2, 3:            return "R2 store misalign";
      5, 6:            return "R6 fetch bus error";
      7, 8, 9, 10, 15, 16: return "R7 data bus error";
      11, 12:          return "R8 priority";
      17:              return "R5 debug hold";
      default:         return "R9 idle";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] t, logic m, logic b, logic d, logic s, logic [31:0] a);
    acc_type = t; misalign = m; bus_err = b; debug_mode = d; suppress_dbe = s; fault_addr = a;
  endtask

  task automatic check_all(string req, logic ev, logic [4:0] ec, logic ef, logic ew);
    check({req, " valid"}, {31'd0, exc_valid}, {31'd0, ev});
    check({req, " code"}, {27'd0, exc_code}, {27'd0, ec});
    check({req, " fetch_na R4"}, {31'd0, exc_fetch_na}, {31'd0, ef});
    check({req, " badaddr_we R5"}, {31'd0, badaddr_we}, {31'd0, ew});
    check({req, " badaddr R5"}, badaddr, exp_bad);
  endtask

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    exp_bad = '0;
    rst_n = 1'b0;
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 1'b0, 5'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release", 1'b0, 5'd0, 1'b0, 1'b0);

    // table walk: drive at negedge, result registered at posedge, sample next negedge
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      drive(v[45:44], v[43], v[42], v[41], v[40], v[39:8]);
      @(negedge clk);
      if (v[0]) exp_bad = v[39:8];
      check_all(tag_of(i), v[7], v[6:2], v[1], v[0]);
    end

    // R9: held store misalign gives a pulse each cycle, then idle clears
    drive(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'hB000_0001);
    @(negedge clk);
    exp_bad = 32'hB000_0001;
    check_all("R9 held 1", 1'b1, 5'd5, 1'b0, 1'b1);
    fault_addr = 32'hB000_0005;
    @(negedge clk);
    exp_bad = 32'hB000_0005;
    check_all("R9 held 2", 1'b1, 5'd5, 1'b0, 1'b1);
    drive(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'hC000_0000);
    @(negedge clk);
    check_all("R9 idle after", 1'b0, 5'd0, 1'b0, 1'b0);

    // R1: mid-run reset clears outputs asynchronously
    drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hD000_0002);
    @(negedge clk);
    exp_bad = 32'hD000_0002;
    check_all("R1 pre-reset fault", 1'b1, 5'd4, 1'b1, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    exp_bad = '0;
    check_all("R1 async clear", 1'b0, 5'd0, 1'b0, 1'b0);
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after second release", 1'b0, 5'd0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule